// File: doc/BRIEF.md
# PCM Codec Power Sequencing Controller

This block decides when the digital section of a PCM voice codec is awake. It watches three asynchronous inputs: a shared pin that carries either the receive master clock or a static power-down level, and the transmit and receive frame sync strobes. It runs on a free-running reference clock of known frequency. From these inputs it drives a powered-up flag, an enable for the analog output stage, and a drive-permit for the serial PCM data output. While that permit is low, the pad stays in high impedance.

The device can be put to sleep in two ways. The first is a steady high level on the shared pin. The second is frame sync silence: neither strobe has produced a rising edge for a programmable number of reference cycles, sized to about 2 ms. A toggling pin counts as a running clock and never forces sleep. After a wake-up, the data output is held off until the second transmit frame sync is seen. All three inputs pass through two-flop synchronizers before any decision is taken.

Top module: `pcm_pwr_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pwr_up_o`, `dx_en_o` and `ana_en_o` are all 0; the block starts in the asleep state.
- R2: From the asleep state the block wakes (`pwr_up_o` goes to 1) only when a synchronized rising edge appears on `fsx_i` or `fsr_i` while the pin is not in its static-high condition; with no such edge it stays asleep.
- R3: A static high level on `mclk_pd_i` forces the asleep state within a few cycles and blocks any wake-up, whatever the frame sync inputs do.
- R4: When `fsx_i` has produced no rising edge for `IDLE_CYC` reference cycles and `fsr_i` has produced none for `IDLE_CYC` cycles either, the block goes to sleep; a rising edge on either input restarts that input's window.
- R5: After a wake-up, `dx_en_o` rises on the second `fsx_i` rising edge; the edge that caused the wake-up counts as the first.
- R6: Only `fsx_i` edges advance the second-pulse count, and the count is cleared on every entry into the asleep state, so a partial count never survives a sleep.
- R7: `mclk_pd_i` is treated as clocked when it shows both a rising and a falling edge within a window of `DET_WIN` (8) reference cycles; a clocked pin never forces sleep, even while it is momentarily high.
- R8: `ana_en_o` is 1 exactly when `pwr_up_o` is 1, and `dx_en_o` is never 1 while `pwr_up_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_pd_i | input | 1 | Shared receive master clock / power-down pin (asynchronous) |
| fsx_i | input | 1 | Transmit frame sync (asynchronous) |
| fsr_i | input | 1 | Receive frame sync (asynchronous) |
| pwr_up_o | output | 1 | Device is powered up |
| ana_en_o | output | 1 | Analog output stage enable |
| dx_en_o | output | 1 | Serial data output may drive (0 = high impedance) |

## Verification
Wake-up is tried three ways: with a low pin and a transmit strobe, with a low pin and only receive strobes, and with a toggling pin. This separates the "clocked" path from the plain "low level" path, and shows whether receive strobes are wrongly counted toward the second-pulse rule. Sleep is tried by raising the pin, by full strobe silence, and by silence on transmit alone while receive strobes continue. The last case shows whether the timeout wrongly watches the transmit strobe only. A wake, sleep, wake sequence with one transmit pulse in each awake period shows whether the pulse count is cleared on sleep. A clocked pin that stops in the high state shows that a stopped clock turns into a power-down request.

// File: rtl/pcm_pwr_pkg.sv
package pcm_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ASLEEP = 2'd0,
    PS_ARMING = 2'd1,
    PS_LIVE   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcm_clk_detect.sv
// Classifies a synchronized level as clocked or static using fixed windows.
module pcm_clk_detect #(
  parameter int WIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic clocked,
  output logic static_high
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          prev;
  logic [CW-1:0] win_cnt;
  logic          seen_r, seen_f;
  logic          rise, fall;

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      win_cnt <= '0;
      seen_r  <= 1'b0;
      seen_f  <= 1'b0;
      clocked <= 1'b0;
    end else begin
      prev <= lvl;
      if (win_cnt == CW'(WIN - 1)) begin
        win_cnt <= '0;
        clocked <= (seen_r | rise) & (seen_f | fall);
        seen_r  <= 1'b0;
        seen_f  <= 1'b0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        seen_r  <= seen_r | rise;
        seen_f  <= seen_f | fall;
      end
    end
  end

  assign static_high = ~clocked & lvl;
endmodule

// File: rtl/pcm_idle_timer.sv
// Saturating inactivity counter; starts expired, reloads on kick.
module pcm_idle_timer #(
  parameter int LIMIT = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic idle
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= TW'(LIMIT);
    else if (kick)               cnt <= '0;
    else if (cnt != TW'(LIMIT))  cnt <= cnt + 1'b1;
  end

  assign idle = (cnt == TW'(LIMIT));
endmodule

// File: rtl/pcm_pwr_ctrl.sv
module pcm_pwr_ctrl
  import pcm_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DET_WIN     = 8,
  parameter int IDLE_CYC    = 250000,
  parameter int ARM_PULSES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_pd_i,
  input  logic fsx_i,
  input  logic fsr_i,
  output logic pwr_up_o,
  output logic ana_en_o,
  output logic dx_en_o
);
  localparam int CNTW = $clog2(ARM_PULSES + 1);

  logic [2:0] raw_in, sync_in;
  logic       s_pin, s_fsx, s_fsr;
  logic       fsx_prev, fsr_prev;
  logic       fsx_rise, fsr_rise;
  logic       pin_clocked, pin_off;
  logic       tx_idle, rx_idle, silence;

  pwr_state_e      st, st_n;
  logic [CNTW-1:0] arm_cnt, arm_cnt_n;

  assign raw_in = {mclk_pd_i, fsx_i, fsr_i};

  pcm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );
  assign {s_pin, s_fsx, s_fsr} = sync_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsx_prev <= 1'b0;
      fsr_prev <= 1'b0;
    end else begin
      fsx_prev <= s_fsx;
      fsr_prev <= s_fsr;
    end
  end
  assign fsx_rise = s_fsx & ~fsx_prev;
  assign fsr_rise = s_fsr & ~fsr_prev;

  pcm_clk_detect #(.WIN(DET_WIN)) u_pin_det (
    .clk(clk), .rst(rst), .lvl(s_pin),
    .clocked(pin_clocked), .static_high(pin_off)
  );

  pcm_idle_timer #(.LIMIT(IDLE_CYC)) u_tx_idle (
    .clk(clk), .rst(rst), .kick(fsx_rise), .idle(tx_idle)
  );
  pcm_idle_timer #(.LIMIT(IDLE_CYC)) u_rx_idle (
    .clk(clk), .rst(rst), .kick(fsr_rise), .idle(rx_idle)
  );
  assign silence = tx_idle & rx_idle;

  always_comb begin
    st_n      = st;
    arm_cnt_n = arm_cnt;
    unique case (st)
      PS_ASLEEP: begin
        arm_cnt_n = '0;
        if (!pin_off && (fsx_rise || fsr_rise)) begin
          arm_cnt_n = fsx_rise ? CNTW'(1) : '0;
          st_n = (arm_cnt_n >= CNTW'(ARM_PULSES)) ? PS_LIVE : PS_ARMING;
        end
      end
      PS_ARMING: begin
        if (fsx_rise && arm_cnt != CNTW'(ARM_PULSES)) arm_cnt_n = arm_cnt + 1'b1;
        if (arm_cnt_n >= CNTW'(ARM_PULSES)) st_n = PS_LIVE;
      end
      PS_LIVE: ;
      default: st_n = PS_ASLEEP;
    endcase
    if (st != PS_ASLEEP && (pin_off || silence)) begin
      st_n      = PS_ASLEEP;
      arm_cnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PS_ASLEEP;
      arm_cnt  <= '0;
      pwr_up_o <= 1'b0;
      ana_en_o <= 1'b0;
      dx_en_o  <= 1'b0;
    end else begin
      st       <= st_n;
      arm_cnt  <= arm_cnt_n;
      pwr_up_o <= (st_n != PS_ASLEEP);
      ana_en_o <= (st_n != PS_ASLEEP);
      dx_en_o  <= (st_n == PS_LIVE);
    end
  end

  logic unused_ok;
  assign unused_ok = pin_clocked;
endmodule

// File: rtl/pcm_pwr_ctrl_chk.sv
module pcm_pwr_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic fsx_i,
  input logic fsr_i,
  input logic pwr_up_o,
  input logic ana_en_o,
  input logic dx_en_o,
  input logic pin_off,
  input logic silence
);
  // R1: reset leaves every output low
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> (!pwr_up_o && !ana_en_o && !dx_en_o));

  // R2: a wake-up needs a frame sync level seen by the first synchronizer stage
  a_r2_wake_needs_fs: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_up_o) |-> ($past(fsx_i, 3) || $past(fsr_i, 3)));

  // R3: a static-high pin leaves the device asleep next cycle
  a_r3_pin_high_sleep: assert property (@(posedge clk) disable iff (rst)
    pin_off |=> !pwr_up_o);

  // R4: silence on both frame syncs while awake puts the device to sleep
  a_r4_silence_sleep: assert property (@(posedge clk) disable iff (rst)
    (silence && pwr_up_o) |=> !pwr_up_o);

  // R5: the data drive permit never comes up in the wake-up cycle itself
  a_r5_dx_after_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(dx_en_o) |-> $past(pwr_up_o));
endmodule

bind pcm_pwr_ctrl pcm_pwr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .fsx_i(fsx_i), .fsr_i(fsr_i),
  .pwr_up_o(pwr_up_o), .ana_en_o(ana_en_o), .dx_en_o(dx_en_o),
  .pin_off(pin_off), .silence(silence)
);

// File: tb/pcm_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module pcm_pwr_ctrl_tb;
  localparam int IDLE = 100;
  localparam int NSTEPS = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic fsx = 1'b0;
  logic fsr = 1'b0;
  logic [1:0] pin_mode = 2'd0;   // 0 low, 1 high, 2 toggling
  logic [1:0] ph = 2'd0;
  logic pwr_up, ana_en, dx_en;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    ph <= ph + 2'd1;
    case (pin_mode)
      2'd0:    pin <= 1'b0;
      2'd1:    pin <= 1'b1;
      default: pin <= ph[1];
    endcase
  end

  pcm_pwr_ctrl #(.IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst(rst), .mclk_pd_i(pin), .fsx_i(fsx), .fsr_i(fsr),
    .pwr_up_o(pwr_up), .ana_en_o(ana_en), .dx_en_o(dx_en)
  );

  // {mode[1:0], fsx, fsr, wait[7:0], exp_pwr, exp_dx, req[3:0]}
  localparam logic [17:0] STEPS [NSTEPS] = '{
    {2'd0, 1'b0, 1'b0, 8'd20,  1'b0, 1'b0, 4'd2}, // R2 no strobe, stay asleep
    {2'd1, 1'b1, 1'b0, 8'd20,  1'b0, 1'b0, 4'd3}, // R3 high pin blocks wake
    {2'd0, 1'b1, 1'b0, 8'd20,  1'b1, 1'b0, 4'd2}, // R2 wake on fsx
    {2'd0, 1'b1, 1'b0, 8'd20,  1'b1, 1'b1, 4'd5}, // R5 second fsx enables
    {2'd0, 1'b1, 1'b0, 8'd40,  1'b1, 1'b1, 4'd4}, // R4 pulses keep awake
    {2'd0, 1'b0, 1'b0, 8'd40,  1'b1, 1'b1, 4'd4}, // R4 still inside window
    {2'd0, 1'b0, 1'b0, 8'd40,  1'b0, 1'b0, 4'd4}, // R4 timeout sleeps
    {2'd0, 1'b1, 1'b0, 8'd20,  1'b1, 1'b0, 4'd2}, // R2 wake, count 1
    {2'd1, 1'b0, 1'b0, 8'd10,  1'b0, 1'b0, 4'd3}, // R3 high pin sleeps
    {2'd0, 1'b1, 1'b0, 8'd20,  1'b1, 1'b0, 4'd6}, // R6 count cleared by sleep
    {2'd1, 1'b0, 1'b0, 8'd10,  1'b0, 1'b0, 4'd3}, // R3 sleep again
    {2'd0, 1'b0, 1'b1, 8'd20,  1'b1, 1'b0, 4'd2}, // R2 wake on fsr only
    {2'd0, 1'b1, 1'b0, 8'd20,  1'b1, 1'b0, 4'd6}, // R6 fsr did not count
    {2'd0, 1'b1, 1'b0, 8'd20,  1'b1, 1'b1, 4'd5}, // R5 second fsx
    {2'd0, 1'b0, 1'b1, 8'd60,  1'b1, 1'b1, 4'd4}, // R4 fsr activity
    {2'd0, 1'b0, 1'b1, 8'd60,  1'b1, 1'b1, 4'd4}, // R4 fsr alone keeps awake
    {2'd0, 1'b0, 1'b0, 8'd120, 1'b0, 1'b0, 4'd4}, // R4 both silent sleeps
    {2'd2, 1'b0, 1'b0, 8'd30,  1'b0, 1'b0, 4'd7}, // R7 clock alone no wake
    {2'd2, 1'b1, 1'b0, 8'd30,  1'b1, 1'b0, 4'd7}, // R7 clocked pin wakes
    {2'd2, 1'b1, 1'b0, 8'd30,  1'b1, 1'b1, 4'd7}, // R7 clock keeps awake
    {2'd1, 1'b0, 1'b0, 8'd40,  1'b0, 1'b0, 4'd3}  // R3 clock stopped high
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pwr,ana,dx} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic on_x, input logic on_r);
    @(negedge clk);
    fsx = on_x;
    fsr = on_r;
    repeat (2) @(negedge clk);
    fsx = 1'b0;
    fsr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {pwr_up, ana_en, dx_en}, 3'b000);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {pwr_up, ana_en, dx_en}, 3'b000);

    for (int i = 0; i < NSTEPS; i++) begin
      logic [17:0] s;
      s = STEPS[i];
      pin_mode = s[17:16];
      repeat (4) @(negedge clk);
      if (s[15] || s[14]) pulse(s[15], s[14]);
      repeat (int'(s[13:6])) @(negedge clk);
      chk($sformatf("R%0d step %0d", s[3:0], i), {pwr_up, ana_en, dx_en},
          {s[5], s[5], s[4]});
      chk($sformatf("R8 step %0d", i), {1'b0, ana_en, 1'b0}, {1'b0, pwr_up, 1'b0});
    end

    // R1: reset in the middle of operation
    pin_mode = 2'd0;
    repeat (4) @(negedge clk);
    pulse(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    pulse(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R5 before mid reset", {pwr_up, ana_en, dx_en}, 3'b111);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid reset", {pwr_up, ana_en, dx_en}, 3'b000);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 no strobe after reset", {pwr_up, ana_en, dx_en}, 3'b000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule